// File: doc/BRIEF.md
# Phase-Lockable PWM Timer for One Output Pair

This block is a PWM timer that drives one pair of outputs, A and B. A counter steps on every clock and runs up to a programmed period. It either wraps back to zero or turns around and counts back down. Two compare values turn the count into waveforms. The pair can act as two independent single-edge outputs, as two independent centre-aligned outputs, or as one output whose rising and falling edges are placed separately, with B carrying its complement.

Several copies of the timer can be chained so that they run as one system. Each copy has a sync input. When phase loading is enabled, a pulse on that input loads a programmed phase value into the counter. A copy that takes its sync from the previous copy's zero pulse therefore holds a fixed lead or lag, and the relationship is re-established on every PWM cycle. The sync output either marks the counter's zero or forwards the sync input along the chain. A second sync output marks the period point for neighbouring logic. Software can force either output to a fixed level at any moment, whatever the counter is doing. Registers are written through a simple one-cycle write port.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset every register is zero, the count is 0 and counts up, A and B are low, and sync_out is high because the count is 0.
- R2: In mode 0 (and in mode 3, which behaves the same) the count goes 0,1,…,P and then returns to 0, where P is the active period, giving P+1 clocks per cycle; count_down stays 0.
- R3: In modes 1 and 2 the count rises 0..P and then falls back to 0, so one cycle is 2P clocks. count_down is 1 while the count falls. At P the count turns down, and at 0 it turns up. With P=0 the count stays at 0.
- R4: The period (address 0), compare A (address 2) and compare B (address 3) are written to shadow copies. The active values take the shadow values only on a clock edge where the count was 0, so a cycle already running keeps its old values.
- R5: In modes 0, 1 and 3, A is high while count < active compare A, and B is high while count < active compare B.
- R6: In mode 2, while counting up A is high when count >= compare A. While counting down A is high when count >= compare B. B is the inverse of A.
- R7: With phase loading enabled (control bit 2), a clock edge that samples sync_in high loads the phase register (address 1) into the count and sets the direction to up. With that bit clear, sync_in has no effect on the count.
- R8: With control bit 3 clear, sync_out is high exactly while the count is 0. With it set, sync_out follows sync_in combinationally.
- R9: sync_per is high exactly while the count equals the active period.
- R10: Control bit 4 forces A to the value of bit 5, and bit 6 forces B to the value of bit 7. The force applies from the edge that writes the control register, whatever the count.
- R11: A second timer with phase loading enabled, whose sync_in is fed from the first timer's sync_out, keeps a constant count offset from the first timer on every clock. The offset equals phase − 1 modulo P+1 when both run mode 0 with the same period P.
- R12: Control lives at address 4, with mode in bits 1:0 and the remaining bits as listed above. Control changes take effect on the next edge. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Sync pulse from the previous timer in the chain |
| sync_out | output | 1 | Sync pulse toward the next timer |
| sync_per | output | 1 | High while the count sits at the period |
| count | output | 16 | Current counter value |
| count_down | output | 1 | High while counting down |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The assertions assume that sync_in and the write port only change between clock edges and never carry unknown values after reset. The stimulus meets this by driving every input one time unit after a rising edge. The period checks assume that the count is not left above the period by a phase load. The stimulus keeps every phase value below the programmed period. The bench checks the chained pair only while both timers run the same period in mode 0, with the downstream timer taking its sync from the upstream timer's zero pulse.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_SYM  = 2'd1,
    MODE_ASYM = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  // Bit order is the software-visible control layout (mode in bits 1:0).
  typedef struct packed {
    logic  ovr_b_val;
    logic  ovr_b_en;
    logic  ovr_a_val;
    logic  ovr_a_en;
    logic  sync_sel;
    logic  phase_en;
    mode_e mode;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [2:0] ADDR_PER   = 3'd0;
  localparam logic [2:0] ADDR_PHASE = 3'd1;
  localparam logic [2:0] ADDR_CMPA  = 3'd2;
  localparam logic [2:0] ADDR_CMPB  = 3'd3;
  localparam logic [2:0] ADDR_CTL   = 3'd4;

  function automatic logic is_updown(input mode_e m);
    return (m == MODE_SYM) || (m == MODE_ASYM);
  endfunction

endpackage

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          shadow_load,
  output logic [CW-1:0] per_act,
  output logic [CW-1:0] cmpa_act,
  output logic [CW-1:0] cmpb_act,
  output logic [CW-1:0] per_shd,
  output logic [CW-1:0] phase_q,
  output ctl_t          ctl_q
);

  logic [CW-1:0] cmpa_shd, cmpb_shd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_shd  <= '0;
      cmpa_shd <= '0;
      cmpb_shd <= '0;
      phase_q  <= '0;
      ctl_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(ADDR_PER):   per_shd  <= wr_data;
        AW'(ADDR_PHASE): phase_q  <= wr_data;
        AW'(ADDR_CMPA):  cmpa_shd <= wr_data;
        AW'(ADDR_CMPB):  cmpb_shd <= wr_data;
        AW'(ADDR_CTL):   ctl_q    <= ctl_t'(wr_data[CTL_W-1:0]);
        default: ;
      endcase
    end
  end

  // Active copies move only at the count-zero boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else if (shadow_load) begin
      per_act  <= per_shd;
      cmpa_act <= cmpa_shd;
      cmpb_act <= cmpb_shd;
    end
  end

endmodule

// File: rtl/pwm_sync_counter.sv
module pwm_sync_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          updown,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] phase,
  input  logic          sync_load,
  output logic [CW-1:0] count,
  output logic          down
);

  // Returns {next_direction, next_count}.
  function automatic logic [CW:0] advance(input logic [CW-1:0] c,
                                          input logic          dn,
                                          input logic          ud,
                                          input logic [CW-1:0] p);
    logic [CW:0] r;
    if (!ud)
      r = {1'b0, (c >= p) ? {CW{1'b0}} : c + 1'b1};
    else if (p == '0)
      r = '0;
    else if (!dn)
      r = (c >= p) ? {1'b1, c - 1'b1} : {1'b0, c + 1'b1};
    else
      r = (c == '0) ? {1'b0, c + 1'b1} : {1'b1, c - 1'b1};
    return r;
  endfunction

  logic [CW:0] nxt;
  assign nxt = advance(count, down, updown, period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      down  <= 1'b0;
    end else if (sync_load) begin
      count <= phase;
      down  <= 1'b0;
    end else begin
      count <= nxt[CW-1:0];
      down  <= nxt[CW];
    end
  end

endmodule

// File: rtl/pwm_sync_compare.sv
module pwm_sync_compare
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] count,
  input  logic          down,
  input  logic [CW-1:0] cmpa,
  input  logic [CW-1:0] cmpb,
  input  ctl_t          ctl,
  output logic          pwm_a,
  output logic          pwm_b
);

  function automatic logic below(input logic [CW-1:0] c, input logic [CW-1:0] t);
    return c < t;
  endfunction

  function automatic logic asym_level(input logic [CW-1:0] c, input logic dn,
                                      input logic [CW-1:0] ta, input logic [CW-1:0] tb);
    return dn ? (c >= tb) : (c >= ta);
  endfunction

  logic raw_a, raw_b;

  always_comb begin
    if (ctl.mode == MODE_ASYM) begin
      raw_a = asym_level(count, down, cmpa, cmpb);
      raw_b = ~raw_a;
    end else begin
      raw_a = below(count, cmpa);
      raw_b = below(count, cmpb);
    end
  end

  assign pwm_a = ctl.ovr_a_en ? ctl.ovr_a_val : raw_a;
  assign pwm_b = ctl.ovr_b_en ? ctl.ovr_b_val : raw_b;

endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sync_in,
  output logic          sync_out,
  output logic          sync_per,
  output logic [CW-1:0] count,
  output logic          count_down,
  output logic          pwm_a,
  output logic          pwm_b
);

  logic [CW-1:0] per_act, cmpa_act, cmpb_act, per_shd, phase_q;
  ctl_t          ctl_q;

  // Named internal events, visible to the bound checker.
  logic zero_evt, prd_evt, sync_load, shadow_load, updown;

  assign zero_evt    = (count == '0);
  assign prd_evt     = (count == per_act);
  assign sync_load   = sync_in & ctl_q.phase_en;
  assign shadow_load = zero_evt;
  assign updown      = is_updown(ctl_q.mode);

  pwm_sync_regs #(.CW(CW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shadow_load(shadow_load), .per_act(per_act), .cmpa_act(cmpa_act),
    .cmpb_act(cmpb_act), .per_shd(per_shd), .phase_q(phase_q), .ctl_q(ctl_q)
  );

  pwm_sync_counter #(.CW(CW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .updown(updown), .period(per_act), .phase(phase_q),
    .sync_load(sync_load), .count(count), .down(count_down)
  );

  pwm_sync_compare #(.CW(CW)) cmp_i (
    .count(count), .down(count_down), .cmpa(cmpa_act), .cmpb(cmpb_act),
    .ctl(ctl_q), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  assign sync_out = ctl_q.sync_sel ? sync_in : zero_evt;
  assign sync_per = prd_evt;

endmodule

// File: rtl/pwm_sync_timer_chk.sv
module pwm_sync_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          count_down,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] per_shd,
  input logic [CW-1:0] phase_q,
  input logic          sync_load,
  input logic          shadow_load,
  input logic          updown,
  input logic          asym,
  input logic          ovr_a_en,
  input logic          ovr_a_val,
  input logic          ovr_b_en,
  input logic          pwm_a,
  input logic          pwm_b
);

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!updown && count >= per_act && !sync_load) |=> (count == '0));

  // R3
  turn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && !count_down && per_act != '0 && count >= per_act && !sync_load) |=> count_down);

  // R4
  shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load |=> (per_act == $past(per_shd)));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_load |=> (per_act == $past(per_act)));

  // R7
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_load |=> (count == $past(phase_q) && !count_down));

  // R6
  asym_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asym && !ovr_a_en && !ovr_b_en) |-> (pwm_b != pwm_a));

  // R10
  force_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_a_en |-> (pwm_a == ovr_a_val));

endmodule

bind pwm_sync_timer pwm_sync_timer_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .count(count), .count_down(count_down),
  .per_act(per_act), .per_shd(per_shd), .phase_q(phase_q),
  .sync_load(sync_load), .shadow_load(shadow_load), .updown(updown),
  .asym(ctl_q.mode == pwm_sync_pkg::MODE_ASYM),
  .ovr_a_en(ctl_q.ovr_a_en), .ovr_a_val(ctl_q.ovr_a_val), .ovr_b_en(ctl_q.ovr_b_en),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pwm_sync_timer_tb_top.sv
module pwm_sync_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, s_wr_en = 1'b0, sync_in = 1'b0;
  logic [2:0] wr_addr = '0, s_wr_addr = '0;
  logic [15:0] wr_data = '0, s_wr_data = '0;
  logic sync_out, sync_per, count_down, pwm_a, pwm_b;
  logic [15:0] count;
  logic s_sync_out, s_sync_per, s_down, s_a, s_b;
  logic [15:0] s_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_sync_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .sync_out(sync_out), .sync_per(sync_per), .count(count),
    .count_down(count_down), .pwm_a(pwm_a), .pwm_b(pwm_b));

  pwm_sync_timer slave_i (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
    .sync_in(sync_out), .sync_out(s_sync_out), .sync_per(s_sync_per), .count(s_count),
    .count_down(s_down), .pwm_a(s_a), .pwm_b(s_b));

  int n_chk = 0, n_fail = 0;
  bit done = 0, chain_on = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference of the upstream timer.
  int m_cnt, m_down, m_per, m_ca, m_cb, s_per, s_ca, s_cb, m_ph;
  logic [7:0] m_ctl;

  always @(posedge clk) begin
    int nc, nd, md;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_per = 0; m_ca = 0; m_cb = 0;
      s_per = 0; s_ca = 0; s_cb = 0; m_ph = 0; m_ctl = 0;
    end else begin
      md = m_ctl[1:0];
      if (sync_in && m_ctl[2]) begin nc = m_ph; nd = 0; end
      else if (md == 0 || md == 3) begin nd = 0; nc = (m_cnt >= m_per) ? 0 : m_cnt + 1; end
      else if (m_per == 0) begin nc = 0; nd = 0; end
      else if (m_down == 0) begin
        if (m_cnt >= m_per) begin nd = 1; nc = m_cnt - 1; end
        else begin nd = 0; nc = m_cnt + 1; end
      end else begin
        if (m_cnt == 0) begin nd = 0; nc = 1; end
        else begin nd = 1; nc = m_cnt - 1; end
      end
      if (m_cnt == 0) begin m_per = s_per; m_ca = s_ca; m_cb = s_cb; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: s_per = wr_data;
          3'd1: m_ph = wr_data;
          3'd2: s_ca = wr_data;
          3'd3: s_cb = wr_data;
          3'd4: m_ctl = wr_data[7:0];
          default: ;
        endcase
      end
      m_cnt = nc; m_down = nd;
    end
  end

  always @(negedge clk) begin
    int md; bit ra, rb, ea, eb, so;
    if (rst_n && !done) begin
      md = m_ctl[1:0];
      if (md == 2) begin
        ra = m_down ? (m_cnt >= m_cb) : (m_cnt >= m_ca);
        rb = !ra;
      end else begin
        ra = m_cnt < m_ca; rb = m_cnt < m_cb;
      end
      ea = m_ctl[4] ? m_ctl[5] : ra;
      eb = m_ctl[6] ? m_ctl[7] : rb;
      so = m_ctl[3] ? sync_in : (m_cnt == 0);
      check(count == m_cnt, (md == 1 || md == 2) ? "R3" : "R2", "count", count, m_cnt);
      check(count_down == m_down, "R3", "direction", count_down, m_down);
      check(pwm_a == ea, m_ctl[4] ? "R10" : (md == 2 ? "R6" : "R5"), "pwm_a", pwm_a, ea);
      check(pwm_b == eb, m_ctl[6] ? "R10" : (md == 2 ? "R6" : "R5"), "pwm_b", pwm_b, eb);
      check(sync_out == so, "R8", "sync_out", sync_out, so);
      check(sync_per == (m_cnt == m_per), "R9", "sync_per", sync_per, m_cnt == m_per);
      if (chain_on)
        check(((int'(s_count) - int'(count) + 10) % 10) == 2, "R11", "chain offset",
              (int'(s_count) - int'(count) + 10) % 10, 2);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(1); wr_en = 0;
  endtask

  task automatic swr(input logic [2:0] a, input logic [15:0] d);
    s_wr_en = 1; s_wr_addr = a; s_wr_data = d; step(1); s_wr_en = 0;
  endtask

  task automatic wait_count(input int v);
    int guard = 0;
    while (count != v && guard < 200) begin step(1); guard++; end
  endtask

  initial begin
    int mx, c0;
    step(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(count == 0 && !count_down, "R1", "count after reset", count, 0);
    check(!pwm_a && !pwm_b, "R1", "outputs after reset", {pwm_a, pwm_b}, 0);
    check(sync_out == 1, "R1", "sync_out after reset", sync_out, 1);
    step(1);

    // Single-edge mode, chained follower with phase 3
    wr(3'd0, 16'd9); wr(3'd2, 16'd4); wr(3'd3, 16'd7);
    swr(3'd0, 16'd9); swr(3'd1, 16'd3); swr(3'd4, 16'h0004);
    step(30);
    chain_on = 1;
    step(40);
    chain_on = 0;

    // R12: writes to unused addresses change nothing
    wr(3'd5, 16'd2); wr(3'd6, 16'h00FF); wr(3'd7, 16'd1);
    wait_count(0); step(1);
    mx = 0;
    while (count != 0) begin if (count > mx) mx = count; step(1); end
    check(mx == 9, "R12", "period after unused-address writes", mx, 9);

    // R4: a period written mid-cycle waits for the zero boundary
    wait_count(1);
    wr(3'd0, 16'd5);
    mx = 0;
    while (count != 0) begin if (count > mx) mx = count; step(1); end
    check(mx == 9, "R4", "old period keeps running", mx, 9);
    step(1); mx = 0;
    while (count != 0) begin if (count > mx) mx = count; step(1); end
    check(mx == 5, "R4", "new period after zero", mx, 5);
    wr(3'd0, 16'd9);
    step(25);

    // R10: overrides
    wr(3'd4, 16'h0070);
    step(15);
    wr(3'd4, 16'h00C0);
    step(15);

    // R3/R5: symmetric up-down
    wr(3'd4, 16'h0001);
    step(45);
    // R6: asymmetric
    wr(3'd2, 16'd3); wr(3'd3, 16'd6); wr(3'd4, 16'h0002);
    step(45);
    // R2: reserved mode counts like mode 0
    wr(3'd4, 16'h0003);
    step(25);

    // R7: phase loading
    wr(3'd4, 16'h0000); wr(3'd1, 16'd6);
    wait_count(2);
    c0 = count;
    sync_in = 1; step(1); sync_in = 0;
    check(count == c0 + 1, "R7", "sync ignored without phase enable", count, c0 + 1);
    wr(3'd4, 16'h0004);
    wait_count(2);
    sync_in = 1; step(1); sync_in = 0;
    check(count == 6, "R7", "phase loaded on sync", count, 6);
    step(13);
    wr(3'd4, 16'h0005);
    wait_count(3);
    sync_in = 1; step(1); sync_in = 0;
    check(count == 6 && !count_down, "R7", "phase load in up-down", count, 6);
    step(20);

    // R8: pass-through of sync_in
    wr(3'd4, 16'h0008);
    sync_in = 1; step(1);
    check(sync_out == 1, "R8", "pass-through high", sync_out, 1);
    sync_in = 0; step(1);
    check(sync_out == 0 || count == 0, "R8", "pass-through low", sync_out, 0);
    step(10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule